// File: doc/BRIEF.md
# Memory-Mapped Network Port

This block gives a small pipelined processor access to an on-chip packet network through two words on its load/store bus. The first word, at a base address, holds payload data. The second word, at base plus 4, holds control and status. Software stores a payload into the data word. It then stores a destination node into the control word, and that store launches a single flit toward the router. The flit carries the destination coordinates above the payload.

Words arriving from the router collect in a small receive buffer. A load from the data word returns the oldest of them and removes it. A load from the control word returns two flags: one says a received word is waiting, and the other says the transmitter can take another send. A blocking or polling send/receive loop in software waits on these flags. Loads are combinational, so the read data is valid in the same cycle as the load strobe.

Top module: `mmnet_if`

## Requirements
- R1: While reset is asserted and right after it, `tx_valid` is 0, `rx_ready` is 1, the receive buffer is empty and the transmitter is ready.
- R2: A load from the data word (`BASE_ADDR`) while received data is waiting returns the oldest received payload. At that clock edge the payload is removed, so each load consumes exactly one word.
- R3: A load from the data word while no received data is waiting returns 0 and removes nothing.
- R4: A store to the control word (`BASE_ADDR+4`) while the transmitter is ready raises `tx_valid` at the next edge. The outgoing flit is then {y, x, payload}: payload in bits [DW-1:0], x in bits [DW+XW-1:DW], y above x. x is taken from control bits [XW-1:0], y from control bits [XW+YW-1:XW], and the payload is the last value stored to the data word.
- R5: From a launched send until the edge on which `tx_valid` and `tx_ready` are both 1, `tx_valid` stays 1, `tx_flit` holds steady and the transmitter reports not ready.
- R6: A store to the control word while the transmitter is not ready is ignored. It produces no extra flit and leaves the pending flit unchanged.
- R7: Stores to the data word while a flit is pending do not alter that flit. The newly stored value is the payload for the next send.
- R8: A load from the control word returns the received-data-waiting flag in bit 0 and the transmitter-ready flag in bit 1. All other bits read 0.
- R9: The receive buffer holds up to `RX_DEPTH` words in arrival order. `rx_ready` is 0 exactly when the buffer is full, and no offered word is lost or reordered.
- R10: Loads from any other address return 0. Stores to any other address change neither the staged payload nor the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Processor byte address |
| bus_wr | input | 1 | Store strobe |
| bus_rd | input | 1 | Load strobe |
| bus_wdata | input | DW | Store data |
| bus_rdata | output | DW | Load data, combinational |
| tx_valid | output | 1 | Outgoing flit valid |
| tx_ready | input | 1 | Router accepts the outgoing flit |
| tx_flit | output | XW+YW+DW | Outgoing flit {y, x, payload} |
| rx_valid | input | 1 | Router offers a received payload |
| rx_ready | output | 1 | Receive buffer has room |
| rx_data | input | DW | Received payload |

## Verification
The bench builds the block with a 32-bit address and data path, 4-bit x and y fields, a base address of 0x8000_0000 and a four-entry receive buffer. The short buffer lets both the full state (`rx_ready` low while words are still offered) and the empty state be reached many times within a short random run. The narrow coordinate fields let random control-word stores carry junk in the upper bits, so field extraction is tested. Directed sequences hold `tx_ready` low while extra sends and data stores arrive, which exercises the ignored-send and stable-flit cases.

// File: rtl/mmnet_pkg.sv
package mmnet_pkg;

   // Decoded target of a bus access
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DATA = 2'd1,
      SEL_CTRL = 2'd2
   } mmnet_sel_e;

   // Status word bit positions (software polls these)
   localparam int unsigned STAT_RXAVAIL_BIT = 0;
   localparam int unsigned STAT_TXFREE_BIT  = 1;

   // Byte offset of the control/status word from the data word
   localparam int unsigned CTRL_OFFSET = 4;

endpackage

// File: rtl/mmnet_decode.sv
module mmnet_decode
   import mmnet_pkg::*;
#(
   parameter int unsigned    AW        = 32,
   parameter logic [AW-1:0]  BASE_ADDR = '0
) (
   input  logic [AW-1:0] addr,
   input  logic          rd,
   input  logic          wr,
   output mmnet_sel_e    sel,
   output logic          rd_data,
   output logic          rd_ctrl,
   output logic          wr_data,
   output logic          wr_ctrl
);

   localparam logic [AW-1:0] CTRL_ADDR = BASE_ADDR + AW'(CTRL_OFFSET);

   always_comb begin
      if (addr == BASE_ADDR) begin
         sel = SEL_DATA;
      end else if (addr == CTRL_ADDR) begin
         sel = SEL_CTRL;
      end else begin
         sel = SEL_NONE;
      end
   end

   assign rd_data = rd && (sel == SEL_DATA);
   assign rd_ctrl = rd && (sel == SEL_CTRL);
   assign wr_data = wr && (sel == SEL_DATA);
   assign wr_ctrl = wr && (sel == SEL_CTRL);

endmodule

// File: rtl/mmnet_tx.sv
module mmnet_tx #(
   parameter int unsigned DW = 32,
   parameter int unsigned XW = 4,
   parameter int unsigned YW = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               stage_we,
   input  logic [DW-1:0]      stage_d,
   input  logic               send_req,
   input  logic [XW-1:0]      dest_x,
   input  logic [YW-1:0]      dest_y,
   output logic               send_rdy,
   output logic               tx_valid,
   input  logic               tx_ready,
   output logic [XW+YW+DW-1:0] tx_flit
);

   localparam int unsigned FW = XW + YW + DW;

   logic [DW-1:0] stage_q;
   logic [FW-1:0] flit_q;
   logic          pend_q;
   logic          launch;

   // Staging register: free to change at any time, the flit is a copy
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else if (stage_we) begin
         stage_q <= stage_d;
      end
   end

   assign launch = send_req && !pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         flit_q <= '0;
      end else if (launch) begin
         pend_q <= 1'b1;
         flit_q <= {dest_y, dest_x, stage_q};
      end else if (pend_q && tx_ready) begin
         pend_q <= 1'b0;
      end
   end

   assign send_rdy = !pend_q;
   assign tx_valid = pend_q;
   assign tx_flit  = flit_q;

endmodule

// File: rtl/mmnet_rx.sv
module mmnet_rx #(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [DW-1:0] in_data,
   input  logic          pop,
   output logic          avail,
   output logic [DW-1:0] head
);

   generate
      if (DEPTH == 1) begin : g_single
         logic          full_q;
         logic [DW-1:0] word_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               full_q <= 1'b0;
               word_q <= '0;
            end else if (in_valid && (!full_q || pop)) begin
               full_q <= 1'b1;
               word_q <= in_data;
            end else if (pop) begin
               full_q <= 1'b0;
            end
         end

         // Single slot: a pop frees room in the same cycle
         assign in_ready = !full_q || pop;
         assign avail    = full_q;
         assign head     = word_q;
      end else begin : g_ring
         localparam int unsigned PW = $clog2(DEPTH);
         localparam int unsigned CW = $clog2(DEPTH + 1);
         localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
         localparam logic [CW-1:0] FULL = CW'(DEPTH);

         logic [DW-1:0] mem [DEPTH];
         logic [PW-1:0] wr_ptr, rd_ptr;
         logic [CW-1:0] cnt;
         logic          do_push, do_pop;

         assign do_pop  = pop && (cnt != '0);
         assign do_push = in_valid && (cnt != FULL);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_ptr <= '0;
               rd_ptr <= '0;
               cnt    <= '0;
            end else begin
               if (do_push) begin
                  wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
               end
               if (do_pop) begin
                  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
               end
               if (do_push && !do_pop) begin
                  cnt <= cnt + 1'b1;
               end else if (do_pop && !do_push) begin
                  cnt <= cnt - 1'b1;
               end
            end
         end

         always_ff @(posedge clk) begin
            if (do_push) begin
               mem[wr_ptr] <= in_data;
            end
         end

         assign in_ready = (cnt != FULL);
         assign avail    = (cnt != '0);
         assign head     = mem[rd_ptr];
      end
   endgenerate

endmodule

// File: rtl/mmnet_if.sv
module mmnet_if
   import mmnet_pkg::*;
#(
   parameter int unsigned   AW        = 32,
   parameter int unsigned   DW        = 32,
   parameter int unsigned   XW        = 4,
   parameter int unsigned   YW        = 4,
   parameter int unsigned   RX_DEPTH  = 4,
   parameter logic [AW-1:0] BASE_ADDR = 32'h8000_0000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [AW-1:0]        bus_addr,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [DW-1:0]        bus_wdata,
   output logic [DW-1:0]        bus_rdata,
   output logic                 tx_valid,
   input  logic                 tx_ready,
   output logic [XW+YW+DW-1:0]  tx_flit,
   input  logic                 rx_valid,
   output logic                 rx_ready,
   input  logic [DW-1:0]        rx_data
);

   localparam int unsigned DESTW = XW + YW;

   // Elaboration-time parameter checks
   generate
      if (DESTW > DW) begin : g_bad_dest
         $error("mmnet_if: XW+YW must fit in DW");
      end
      if (DW < 2) begin : g_bad_dw
         $error("mmnet_if: DW must hold both status flags");
      end
      if (RX_DEPTH < 1) begin : g_bad_depth
         $error("mmnet_if: RX_DEPTH must be at least 1");
      end
      if (BASE_ADDR[1:0] != 2'b00) begin : g_bad_base
         $error("mmnet_if: BASE_ADDR must be word aligned");
      end
   endgenerate

   mmnet_sel_e  sel;
   logic        rd_data, rd_ctrl, wr_data, wr_ctrl;
   logic        send_rdy;
   logic        rx_avail;
   logic [DW-1:0] rx_head;
   logic [DW-1:0] status_word;
   logic        unused_wdata;

   mmnet_decode #(
      .AW        (AW),
      .BASE_ADDR (BASE_ADDR)
   ) u_decode (
      .addr    (bus_addr),
      .rd      (bus_rd),
      .wr      (bus_wr),
      .sel     (sel),
      .rd_data (rd_data),
      .rd_ctrl (rd_ctrl),
      .wr_data (wr_data),
      .wr_ctrl (wr_ctrl)
   );

   mmnet_tx #(
      .DW (DW),
      .XW (XW),
      .YW (YW)
   ) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .stage_we (wr_data),
      .stage_d  (bus_wdata),
      .send_req (wr_ctrl),
      .dest_x   (bus_wdata[XW-1:0]),
      .dest_y   (bus_wdata[DESTW-1:XW]),
      .send_rdy (send_rdy),
      .tx_valid (tx_valid),
      .tx_ready (tx_ready),
      .tx_flit  (tx_flit)
   );

   mmnet_rx #(
      .DW    (DW),
      .DEPTH (RX_DEPTH)
   ) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (rx_valid),
      .in_ready (rx_ready),
      .in_data  (rx_data),
      .pop      (rd_data),
      .avail    (rx_avail),
      .head     (rx_head)
   );

   always_comb begin
      status_word = '0;
      status_word[STAT_RXAVAIL_BIT] = rx_avail;
      status_word[STAT_TXFREE_BIT]  = send_rdy;
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_data && rx_avail) begin
         bus_rdata = rx_head;
      end else if (rd_ctrl) begin
         bus_rdata = status_word;
      end
   end

   generate
      if (DESTW < DW) begin : g_wd_spare
         assign unused_wdata = ^bus_wdata[DW-1:DESTW] ^ (sel == SEL_NONE);
      end else begin : g_wd_full
         assign unused_wdata = (sel == SEL_NONE);
      end
   endgenerate

endmodule

// File: rtl/mmnet_if_chk.sv
module mmnet_if_chk #(
   parameter int unsigned   AW        = 32,
   parameter int unsigned   DW        = 32,
   parameter int unsigned   XW        = 4,
   parameter int unsigned   YW        = 4,
   parameter int unsigned   RX_DEPTH  = 4,
   parameter logic [AW-1:0] BASE_ADDR = 32'h8000_0000
) (
   input logic                clk,
   input logic                rst_n,
   input logic [AW-1:0]       bus_addr,
   input logic                bus_wr,
   input logic                bus_rd,
   input logic [DW-1:0]       bus_wdata,
   input logic [DW-1:0]       bus_rdata,
   input logic                tx_valid,
   input logic                tx_ready,
   input logic [XW+YW+DW-1:0] tx_flit,
   input logic                rx_valid,
   input logic                rx_ready,
   input logic [DW-1:0]       rx_data
);

   localparam int unsigned    FW    = XW + YW + DW;
   localparam logic [AW-1:0]  CADDR = BASE_ADDR + AW'(4);

   logic is_data, is_ctrl;
   int unsigned occ;
   logic unused_rxd;

   assign is_data    = (bus_addr == BASE_ADDR);
   assign is_ctrl    = (bus_addr == CADDR);
   assign unused_rxd = ^rx_data;

   // Independent occupancy count from the port handshakes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ <= 0;
      end else begin
         occ <= occ + ((rx_valid && rx_ready) ? 1 : 0)
                    - ((bus_rd && is_data && occ != 0) ? 1 : 0);
      end
   end

   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |-> (!tx_valid && rx_ready));

   p_empty_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && is_data && occ == 0) |-> (bus_rdata == '0));

   p_send_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && is_ctrl && !tx_valid) |=>
         (tx_valid && tx_flit[FW-1:DW] == $past(bus_wdata[XW+YW-1:0])));

   p_flit_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_flit)));

   p_busy_send_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready && bus_wr && is_ctrl) |=> $stable(tx_flit));

   p_status_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && is_ctrl) |->
         (bus_rdata[0] == (occ != 0) && bus_rdata[1] == !tx_valid
          && bus_rdata[DW-1:2] == '0));

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (occ <= RX_DEPTH) && (RX_DEPTH == 1 || rx_ready == (occ < RX_DEPTH)));

   p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !is_data && !is_ctrl) |-> (bus_rdata == '0));

endmodule

bind mmnet_if mmnet_if_chk #(
   .AW        (AW),
   .DW        (DW),
   .XW        (XW),
   .YW        (YW),
   .RX_DEPTH  (RX_DEPTH),
   .BASE_ADDR (BASE_ADDR)
) u_chk (.*);

// File: tb/mmnet_if_test.sv
`timescale 1ns/1ps
module mmnet_if_test;

   localparam int unsigned AW = 32;
   localparam int unsigned DW = 32;
   localparam int unsigned XW = 4;
   localparam int unsigned YW = 4;
   localparam int unsigned DEPTH = 4;
   localparam int unsigned FW = XW + YW + DW;
   localparam logic [31:0] BASE = 32'h8000_0000;

   localparam int OP_IDLE = 0, OP_WDATA = 1, OP_WCTRL = 2, OP_RDATA = 3,
                  OP_RCTRL = 4, OP_WOTHER = 5, OP_ROTHER = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          tx_valid;
   logic          tx_ready = 1'b0;
   logic [FW-1:0] tx_flit;
   logic          rx_valid = 1'b0;
   logic          rx_ready;
   logic [DW-1:0] rx_data = '0;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // Bench model
   logic [DW-1:0] mq [DEPTH];
   int            mn = 0;
   logic [DW-1:0] m_stage = '0;
   bit            m_txv = 0;
   logic [FW-1:0] m_flit = '0;

   always #2.5 clk = ~clk;

   mmnet_if #(
      .AW(AW), .DW(DW), .XW(XW), .YW(YW), .RX_DEPTH(DEPTH), .BASE_ADDR(BASE)
   ) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_flit(tx_flit),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [FW-1:0] exp_flit(logic [DW-1:0] ctl, logic [DW-1:0] pay);
      return {ctl[XW+YW-1:XW], ctl[XW-1:0], pay};
   endfunction

   function automatic logic [DW-1:0] exp_status(int n, bit txv);
      logic [DW-1:0] s = '0;
      s[0] = (n != 0);
      s[1] = !txv;
      return s;
   endfunction

   function automatic logic [31:0] other_addr(int k);
      case (k % 3)
         0: return BASE + 32'd8;
         1: return BASE - 32'd4;
         default: return 32'h0000_0004;
      endcase
   endfunction

   // One bus/router cycle, entered and left at a falling edge
   task automatic step(input int op, input logic [DW-1:0] wd, input bit rxv,
                       input logic [DW-1:0] rxd, input bit txr);
      bit accept_tx;
      chk(tx_valid === m_txv, "R4 R5 R6 tx_valid", 64'(tx_valid), 64'(m_txv));
      if (m_txv) chk(tx_flit === m_flit, "R6 R7 tx_flit", 64'(tx_flit), 64'(m_flit));
      chk(rx_ready === (mn < DEPTH), "R9 rx_ready", 64'(rx_ready), 64'(mn < DEPTH));

      bus_wr    = (op == OP_WDATA || op == OP_WCTRL || op == OP_WOTHER);
      bus_rd    = (op == OP_RDATA || op == OP_RCTRL || op == OP_ROTHER);
      bus_wdata = wd;
      case (op)
         OP_WDATA, OP_RDATA: bus_addr = BASE;
         OP_WCTRL, OP_RCTRL: bus_addr = BASE + 32'd4;
         OP_WOTHER, OP_ROTHER: bus_addr = other_addr(int'(wd[1:0]));
         default: bus_addr = BASE + 32'd4;
      endcase
      rx_valid = rxv;
      rx_data  = rxd;
      tx_ready = txr;
      #1;
      if (op == OP_RDATA) begin
         if (mn != 0) chk(bus_rdata === mq[0], "R2 data read", 64'(bus_rdata), 64'(mq[0]));
         else chk(bus_rdata === '0, "R3 empty read", 64'(bus_rdata), 64'd0);
      end
      if (op == OP_RCTRL)
         chk(bus_rdata === exp_status(mn, m_txv), "R8 status read",
             64'(bus_rdata), 64'(exp_status(mn, m_txv)));
      if (op == OP_ROTHER)
         chk(bus_rdata === '0, "R10 unmapped read", 64'(bus_rdata), 64'd0);

      // Model update for the coming edge
      accept_tx = m_txv && txr;
      if (op == OP_WCTRL && !m_txv) begin
         m_flit = exp_flit(wd, m_stage);
         m_txv  = 1;
      end else if (accept_tx) begin
         m_txv = 0;
      end
      if (op == OP_WDATA) m_stage = wd;
      begin
         bit push = rxv && (mn < DEPTH);
         bit pop  = (op == OP_RDATA) && (mn != 0);
         if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) mq[i] = mq[i+1];
            mn--;
         end
         if (push) begin
            mq[mn] = rxd;
            mn++;
         end
      end
      @(negedge clk);
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd12345));
      repeat (3) @(negedge clk);
      // R1: outputs during reset
      chk(tx_valid === 1'b0, "R1 tx_valid in reset", 64'(tx_valid), 64'd0);
      chk(rx_ready === 1'b1, "R1 rx_ready in reset", 64'(rx_ready), 64'd1);
      rst_n = 1'b1;
      @(negedge clk);
      bus_rd = 1'b1;
      bus_addr = BASE + 32'd4;
      #1;
      chk(bus_rdata === 32'h2, "R1 status after reset", 64'(bus_rdata), 64'h2);
      bus_rd = 1'b0;
      @(negedge clk);

      // R9: fill buffer, then offer one more while full
      for (int i = 0; i < 5; i++) step(OP_IDLE, '0, 1, 32'hA000_0000 + 32'(i), 0);
      step(OP_RCTRL, '0, 1, 32'hDEAD_BEEF, 0);
      // R2: drain in order, R3: one more read on empty
      for (int i = 0; i < 5; i++) step(OP_RDATA, '0, 0, '0, 0);
      step(OP_RCTRL, '0, 0, '0, 0);

      // R4..R7 with the router stalled
      step(OP_WDATA, 32'h1234_5678, 0, '0, 0);
      step(OP_WCTRL, 32'hFFFF_FF3A, 0, '0, 0);
      step(OP_RCTRL, '0, 0, '0, 0);
      step(OP_WDATA, 32'hCAFE_0001, 0, '0, 0);
      step(OP_WCTRL, 32'h0000_0055, 0, '0, 0);
      step(OP_IDLE, '0, 0, '0, 0);
      step(OP_IDLE, '0, 0, '0, 1);
      step(OP_RCTRL, '0, 0, '0, 0);
      // R10: stray store must not change the staged payload
      step(OP_WOTHER, 32'h0BAD_F00D, 0, '0, 0);
      step(OP_ROTHER, 32'h0000_0001, 0, '0, 0);
      step(OP_WCTRL, 32'h0000_0021, 0, '0, 1);
      step(OP_IDLE, '0, 0, '0, 1);

      // Constrained random mix
      for (int n = 0; n < 3000; n++) begin
         int op = int'($urandom_range(0, 6));
         logic [DW-1:0] wd = $urandom;
         bit rxv = ($urandom_range(0, 2) == 0);
         bit txr = ($urandom_range(0, 2) != 0);
         step(op, wd, rxv, $urandom, txr);
      end
      step(OP_IDLE, '0, 0, '0, 1);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule